// File: doc/BRIEF.md
# Selectable-Edge External Trigger Unit

This block watches four asynchronous trigger inputs and turns activity on one of them into a single-cycle trigger event. Software chooses the input and the kind of transition that counts: a rising edge, a falling edge, or either edge. The chosen input passes through a synchroniser and then an edge detector that compares its current synchronised level with the level one cycle earlier.

Each event is sent only to the timer channels whose bit is set in an external-trigger enable mask, and appears there as a one-cycle pulse. The same event sets a sticky status flag. That flag, together with an enable bit, drives an interrupt request.

Software uses two byte registers. The control byte holds the interrupt enable, the edge mode and the input selection. The status byte holds the flag, which is cleared by writing 1 to it. When software switches to another input, the detector's history is reloaded from the new input, so the switch itself never produces an event.

Top module: `edge_trigger_unit`

## Requirements
- R1: After reset, the control byte (address 0x2A) and the status byte (address 0x2B) both read 0x00, irqReq is 0 and chanTrig is all zeros.
- R2: Control bits 1:0 choose the trigger input: value n selects trigIn[n]. Transitions on any other input produce no event.
- R3: Control bits 5:4 choose the edge mode: 00 means rising edge only, 01 means falling edge only, and both 10 and 11 mean either edge.
- R4: A matching transition on the selected input, applied before clock edge k and held, makes chanTrig equal chanEnMask for exactly the one cycle between edges k+1 and k+2. Channels whose mask bit is clear stay 0.
- R5: Each event sets the status flag, which reads as bit 7 of the status byte from edge k+2 onward and stays set until it is cleared.
- R6: Writing a byte with bit 7 set to the status address clears the flag. A write with bit 7 clear has no effect. If an event and a clear happen in the same cycle, the flag stays set.
- R7: irqReq is the AND of control bit 7 (interrupt enable) and the flag. Setting the enable while the flag is already set raises irqReq in the cycle after the write.
- R8: Control bits 6, 3 and 2 and status bits 6:0 always read as 0. Writing 0xFF to the control byte reads back as 0xB3. Reads from any other address return 0x00.
- R9: Changing the selected input never creates an event by itself, even when the new input's level differs from the old one's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register byte address, used for both reads and writes |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| trigIn | input | 4 | Asynchronous trigger inputs |
| chanEnMask | input | NUM_CH | Per-channel external-trigger enable mask |
| chanTrig | output | NUM_CH | Per-channel one-cycle trigger pulses |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench sweeps every input selection against every edge code, including the alias code 11, and toggles each of the four inputs both up and down under a different mask each time. A wrong selection mux or edge decode shows up as a pulse where none is expected, or a missing one, in the exact cycle R4 fixes. It lines up a status clear with the cycle in which the flag is set, and a clear-priority design loses that flag. It also switches the input while the old and new inputs sit at different levels, and a detector that keeps its old history fires a false pulse. It turns on the interrupt enable while the flag is already set, and a design that raises the request only on a new event leaves irqReq low.

// File: rtl/etu_pkg.sv
package etu_pkg;

  localparam int TRIG_SRC_W   = 2;
  localparam int TRIG_NUM_SRC = 1 << TRIG_SRC_W;

  // control byte bit positions (software decodes these)
  localparam int CTRL_IE_BIT   = 7;
  localparam int CTRL_EDGE_LSB = 4;
  localparam int CTRL_SRC_LSB  = 0;
  localparam int STAT_FLAG_BIT = 7;

  typedef enum logic [1:0] {
    EDGE_RISE    = 2'b00,
    EDGE_FALL    = 2'b01,
    EDGE_ANY     = 2'b10,
    EDGE_ANY_ALT = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic                  intEn;
    edge_mode_e            edgeMode;
    logic [TRIG_SRC_W-1:0] srcSel;
  } trig_cfg_t;

  typedef struct packed {
    logic                  srcLoad;
    logic [TRIG_SRC_W-1:0] loadSrc;
  } trig_strobe_t;

endpackage

// File: rtl/etu_sync.sv
module etu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shQ;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) shQ[0] <= 1'b0;
          else       shQ[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) shQ[s] <= 1'b0;
          else       shQ[s] <= shQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = shQ[STAGES-1];

endmodule

// File: rtl/etu_ctrl.sv
module etu_ctrl
  import etu_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h2A,
  parameter int unsigned STAT_ADDR = 'h2B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              eventPulse,
  output trig_cfg_t         cfg,
  output trig_strobe_t      strobe,
  output logic              statusFlag,
  output logic              irqReq
);

  logic ctrlSel, statSel, ctrlWr, statClr;
  logic [TRIG_SRC_W-1:0] wrSrc;
  trig_cfg_t cfgQ;
  logic flagQ;

  assign ctrlSel = (regAddr == ADDR_W'(CTRL_ADDR));
  assign statSel = (regAddr == ADDR_W'(STAT_ADDR));
  assign ctrlWr  = regWrEn && ctrlSel;
  assign statClr = regWrEn && statSel && regWrData[STAT_FLAG_BIT];
  assign wrSrc   = regWrData[CTRL_SRC_LSB +: TRIG_SRC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctrlWr) begin
      cfgQ.intEn    <= regWrData[CTRL_IE_BIT];
      cfgQ.edgeMode <= edge_mode_e'(regWrData[CTRL_EDGE_LSB +: 2]);
      cfgQ.srcSel   <= wrSrc;
    end
  end

  // event has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flagQ <= 1'b0;
    else if (eventPulse) flagQ <= 1'b1;
    else if (statClr)    flagQ <= 1'b0;
  end

  always_comb begin
    strobe.srcLoad = ctrlWr && (wrSrc != cfgQ.srcSel);
    strobe.loadSrc = wrSrc;
  end

  always_comb begin
    regRdData = 8'h00;
    if (ctrlSel) begin
      regRdData[CTRL_IE_BIT]               = cfgQ.intEn;
      regRdData[CTRL_EDGE_LSB +: 2]        = cfgQ.edgeMode;
      regRdData[CTRL_SRC_LSB +: TRIG_SRC_W] = cfgQ.srcSel;
    end else if (statSel) begin
      regRdData[STAT_FLAG_BIT] = flagQ;
    end
  end

  assign cfg        = cfgQ;
  assign statusFlag = flagQ;
  assign irqReq     = cfgQ.intEn & flagQ;

endmodule

// File: rtl/etu_datapath.sv
module etu_datapath
  import etu_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [TRIG_NUM_SRC-1:0] trigIn,
  input  logic [NUM_CH-1:0]       chanEnMask,
  input  trig_cfg_t               cfg,
  input  trig_strobe_t            strobe,
  output logic                    eventPulse,
  output logic [NUM_CH-1:0]       chanTrig
);

  logic [TRIG_NUM_SRC-1:0] syncVal;
  logic [TRIG_SRC_W-1:0]   nextSel;
  logic curLvl, prevQ, roseNow, fellNow;

  genvar i;
  generate
    for (i = 0; i < TRIG_NUM_SRC; i++) begin : g_sync
      etu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .din (trigIn[i]),
        .dout(syncVal[i])
      );
    end
  endgenerate

  assign curLvl  = syncVal[cfg.srcSel];
  assign nextSel = strobe.srcLoad ? strobe.loadSrc : cfg.srcSel;

  // history follows the input that will be selected next cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncVal[nextSel];
  end

  assign roseNow = curLvl & ~prevQ;
  assign fellNow = ~curLvl & prevQ;

  always_comb begin
    unique case (cfg.edgeMode)
      EDGE_RISE: eventPulse = roseNow;
      EDGE_FALL: eventPulse = fellNow;
      default:   eventPulse = roseNow | fellNow;
    endcase
  end

  generate
    for (i = 0; i < NUM_CH; i++) begin : g_fanout
      assign chanTrig[i] = eventPulse & chanEnMask[i];
    end
  endgenerate

endmodule

// File: rtl/edge_trigger_unit.sv
module edge_trigger_unit
  import etu_pkg::*;
#(
  parameter int          NUM_CH      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 8,
  parameter int unsigned CTRL_ADDR   = 'h2A,
  parameter int unsigned STAT_ADDR   = 'h2B
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [7:0]              regWrData,
  output logic [7:0]              regRdData,
  input  logic [TRIG_NUM_SRC-1:0] trigIn,
  input  logic [NUM_CH-1:0]       chanEnMask,
  output logic [NUM_CH-1:0]       chanTrig,
  output logic                    irqReq
);

  trig_cfg_t    cfg;
  trig_strobe_t strobe;
  logic         eventPulse;
  logic         statusFlag;

  etu_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .eventPulse(eventPulse),
    .cfg       (cfg),
    .strobe    (strobe),
    .statusFlag(statusFlag),
    .irqReq    (irqReq)
  );

  etu_datapath #(
    .NUM_CH     (NUM_CH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .chanEnMask(chanEnMask),
    .cfg       (cfg),
    .strobe    (strobe),
    .eventPulse(eventPulse),
    .chanTrig  (chanTrig)
  );

endmodule

// File: rtl/etu_checker.sv
module etu_checker #(
  parameter int          NUM_CH    = 8,
  parameter int          ADDR_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h2A,
  parameter int unsigned STAT_ADDR = 'h2B
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic [NUM_CH-1:0] chanEnMask,
  input logic [NUM_CH-1:0] chanTrig,
  input logic              irqReq,
  input logic              eventPulse,
  input logic              statusFlag
);

  logic clrWr;
  assign clrWr = regWrEn && (regAddr == ADDR_W'(STAT_ADDR)) && regWrData[7];

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chanTrig & ~chanEnMask) == '0);

  assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> statusFlag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlag && !clrWr) |=> statusFlag);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !eventPulse) |=> !statusFlag);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> statusFlag);

  assert_ctrl_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(CTRL_ADDR)) |-> (regRdData[6] == 1'b0 && regRdData[3:2] == 2'b00));

  assert_stat_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(STAT_ADDR)) |-> (regRdData[6:0] == 7'd0));

endmodule

bind edge_trigger_unit etu_checker #(
  .NUM_CH   (NUM_CH),
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .STAT_ADDR(STAT_ADDR)
) u_etu_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .chanEnMask(chanEnMask),
  .chanTrig  (chanTrig),
  .irqReq    (irqReq),
  .eventPulse(eventPulse),
  .statusFlag(statusFlag)
);

// File: tb/edge_trigger_unit_bench.sv
`timescale 1ns/1ps
module edge_trigger_unit_bench;

  localparam int NUM_CH = 8;
  localparam logic [7:0] A_CTRL = 8'h2A;
  localparam logic [7:0] A_STAT = 8'h2B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [3:0] trigIn = 4'h0;
  logic [NUM_CH-1:0] chanEnMask = '0;
  logic [NUM_CH-1:0] chanTrig;
  logic irqReq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  edge_trigger_unit #(.NUM_CH(NUM_CH)) u_edge_trigger_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .trigIn(trigIn),
    .chanEnMask(chanEnMask), .chanTrig(chanTrig), .irqReq(irqReq)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic expEv;
    logic [NUM_CH-1:0] m;

    idle(3);
    // R1 reset state
    rd(A_CTRL, d); check(d == 8'h00, "R1 ctrl reset", d, 8'h00);
    rd(A_STAT, d); check(d == 8'h00, "R1 stat reset", d, 8'h00);
    check(irqReq == 1'b0, "R1 irq reset", irqReq, 0);
    check(chanTrig == '0, "R1 chanTrig reset", chanTrig, 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);

    // R2 R3 R4 R5: sweep source x edge code x input x direction
    for (int src = 0; src < 4; src++) begin
      for (int ed = 0; ed < 4; ed++) begin
        wr(A_CTRL, {2'b00, 2'(ed), 2'b00, 2'(src)});
        rd(A_CTRL, d);
        check(d == {2'b00, 2'(ed), 2'b00, 2'(src)}, "R8 ctrl readback", d, {2'b00, 2'(ed), 2'b00, 2'(src)});
        for (int idx = 0; idx < 4; idx++) begin
          for (int dir = 0; dir < 2; dir++) begin
            m = NUM_CH'(8'hA5 ^ 8'(src * 37 + ed * 11 + idx * 3 + dir));
            chanEnMask = m;
            trigIn[idx] = (dir == 0);
            expEv = (idx == src) &&
                    ((dir == 0) ? (ed != 1) : (ed != 0));
            idle(2);
            check(chanTrig == (expEv ? m : '0), "R4 R2 R3 pulse", chanTrig, expEv ? m : '0);
            idle(1);
            check(chanTrig == '0, "R4 single cycle", chanTrig, 0);
            rd(A_STAT, d);
            check(d == (expEv ? 8'h80 : 8'h00), "R5 flag", d, expEv ? 8'h80 : 8'h00);
            check(irqReq == 1'b0, "R7 irq masked", irqReq, 0);
            if (expEv) wr(A_STAT, 8'h80);
          end
        end
      end
    end

    // R6: event and clear in the same cycle; write of 0 ignored
    chanEnMask = '1;
    wr(A_CTRL, 8'h02);             // src 2, rising
    trigIn[2] = 1'b1;
    idle(2);                       // event visible now
    wr(A_STAT, 8'h80);             // captured on the edge that sets the flag
    rd(A_STAT, d); check(d == 8'h80, "R6 event beats clear", d, 8'h80);
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); check(d == 8'h80, "R6 write0 no effect", d, 8'h80);
    wr(A_STAT, 8'h7F);
    rd(A_STAT, d); check(d == 8'h80, "R6 low bits no effect", d, 8'h80);
    check(irqReq == 1'b0, "R7 irq off while disabled", irqReq, 0);

    // R7: enable with flag already set
    wr(A_CTRL, 8'h82);
    check(irqReq == 1'b1, "R7 immediate irq", irqReq, 1);
    wr(A_STAT, 8'h80);
    rd(A_STAT, d); check(d == 8'h00, "R6 clear", d, 8'h00);
    check(irqReq == 1'b0, "R7 irq drops on clear", irqReq, 0);
    trigIn[2] = 1'b0;              // falling: ignored in rising mode
    idle(4);
    check(irqReq == 1'b0, "R3 fall ignored", irqReq, 0);
    trigIn[2] = 1'b1;
    idle(3);
    check(irqReq == 1'b1, "R7 irq on new event", irqReq, 1);
    wr(A_STAT, 8'h80);

    // R9: input switch with differing levels
    trigIn = 4'b0010;
    wr(A_CTRL, 8'h20);             // src 0, any edge
    idle(4);
    wr(A_STAT, 8'h80);
    wr(A_CTRL, 8'h21);             // switch to src 1 (high)
    for (int c = 0; c < 4; c++) begin
      check(chanTrig == '0, "R9 no false event", chanTrig, 0);
      @(negedge clk);
    end
    rd(A_STAT, d); check(d == 8'h00, "R9 flag stays clear", d, 8'h00);
    wr(A_CTRL, 8'h20);             // switch back to src 0 (low)
    for (int c = 0; c < 4; c++) begin
      check(chanTrig == '0, "R9 no false event back", chanTrig, 0);
      @(negedge clk);
    end
    rd(A_STAT, d); check(d == 8'h00, "R9 flag clear back", d, 8'h00);

    // R8: reserved bits, status bits, other addresses
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, d); check(d == 8'hB3, "R8 ctrl mask", d, 8'hB3);
    rd(8'h00, d); check(d == 8'h00, "R8 other addr", d, 8'h00);
    rd(8'h2C, d); check(d == 8'h00, "R8 other addr 2C", d, 8'h00);
    wr(A_STAT, 8'h7F);
    rd(A_STAT, d); check(d == 8'h00, "R8 stat reserved", d, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule